// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block is one receive channel of a serial controller. It watches a single asynchronous serial line with a sampling clock of 1, 16, 32 or 64 times the bit rate. It finds each start bit, then samples the data, parity and stop bits at the middle of their bit periods. Each finished character goes into one holding register, and error flags collect in a status byte.

Control fields choose the character length, stop bits, parity and receive interrupt behaviour. These fields come from a control register that sits elsewhere. The surrounding logic reads the character with a one-cycle read pulse. It clears the error flags with an error-clear pulse, and it re-arms first-character interrupts with an arm pulse. The interrupt request is a level signal and follows the selected mode.

Top module: `serial_rx_channel`

## Requirements
- R1: After reset the status byte reads 0x00, the interrupt request is low, and first-character interrupts are armed.
- R2: The divisor field maps 00→×1, 01→×16, 10→×32 and 11→×64 sampling clocks per bit. For divisors above 1, a start bit is accepted only if the line is still low at the mid-bit sample. A shorter low pulse is dropped and produces no character.
- R3: The length field maps 00→5, 01→7, 10→6 and 11→8 data bits. Data arrives least significant bit first, and the unused upper bits of the holding register read as 1.
- R4: When parity is enabled, a mismatch sets status bit 4 (0x10). The even/odd select chooses the check: even means the data bits and the parity bit hold an even number of ones. With parity off no parity bit is expected.
- R5: Every stop bit is sampled at its middle, and a low stop sample sets status bit 6 (0x40). The stop field maps 01→1, 10→1.5 and 11→2 stop bits, and 00 acts as 1. The 1.5 setting acts as 1 when the divisor is ×1.
- R6: If a character completes while the previous one is still unread, status bit 5 (0x20) is set and the new character replaces the old one.
- R7: Status bit 0 (0x01) is set when a character completes and is cleared by the read pulse.
- R8: The error bits 6, 5 and 4 stay set until an error-clear pulse. A later error-free character does not clear them.
- R9: With the receiver enable low the line is ignored and no character is produced.
- R10: Interrupt mode 00 never raises the interrupt request.
- R11: Interrupt mode 01 raises the request for the first character after arming, until that character is read. Later characters raise nothing until the arm pulse is given again. Special conditions also raise the request.
- R12: Interrupt mode 10 raises the request while a character waits and while a special condition is recorded.
- R13: Interrupt mode 11 raises the request only for special conditions. Framing and overrun errors always count as special conditions. A parity error counts only when the parity-special control bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (divisor times the bit rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_clk_div | input | 2 | Sampling divisor code |
| cfg_char_len | input | 2 | Character length code |
| cfg_stop | input | 2 | Stop-bit code |
| cfg_par_en | input | 1 | Parity check enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_par_sc | input | 1 | Parity error counts as special condition |
| cfg_int_mode | input | 2 | Receive interrupt mode |
| cmd_rd_data | input | 1 | Read pulse: consumes the held character |
| cmd_err_clr | input | 1 | Clears the sticky error bits |
| cmd_arm_first | input | 1 | Re-arms the first-character interrupt |
| rd_data | output | 8 | Holding register |
| rx_status | output | 8 | Status: bit6 framing, bit5 overrun, bit4 parity, bit0 ready |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The bench builds the channel with the default counter width of 7 bits, which is exactly enough to hold the ×64 bit period. This lets every divisor code be exercised at run time, including the widest count. The bench pairs each length code with a different divisor, so the non-monotonic length decode and the mid-bit timing are both checked. It also exercises the 1.5 stop setting at ×16 and at ×1, plus all four interrupt modes, including re-arming in first-character mode.

// File: rtl/rx_cfg_pkg.sv
// Package: shared types and field decoders for the serial receive channel.
// Assumes a character width of at most 8 data bits.
package rx_cfg_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP1,
        RX_STOP2
    } rx_state_t;

    // Length field decoder (non-monotonic code order)
    function automatic logic [3:0] len_of(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd5;
            2'b01:   return 4'd7;
            2'b10:   return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

    // Divisor field decoder: sampling clocks per bit period
    function automatic logic [6:0] period_of(input logic [1:0] code);
        case (code)
            2'b00:   return 7'd1;
            2'b01:   return 7'd16;
            2'b10:   return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

endpackage

// File: rtl/rx_frame_engine.sv
// Frame engine: detects start bits and samples each following bit at
// mid-period, then emits a one-cycle completion pulse with the aligned
// character and its parity/framing results.
// Assumes CNT_W holds the largest bit period (64 -> 7 bits).
module rx_frame_engine
    import rx_cfg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              en,
    input  logic [1:0]        clk_div,
    input  logic [1:0]        char_len,
    input  logic [1:0]        stop_sel,
    input  logic              par_en,
    input  logic              par_even,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              done_pe,
    output logic              done_fe
);
    localparam int BIT_W = $clog2(DATA_W + 2);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              acc;
    logic              fe_first;

    logic [CNT_W-1:0]  period, half, three_q;
    logic [BIT_W-1:0]  len, nbits;
    logic              two_stop, one_half, is_x1;
    logic [DATA_W-1:0] aligned;
    logic              par_bad;

    // Decode control fields into counts used by the sequencer
    always_comb begin
        period   = CNT_W'(period_of(clk_div));
        half     = period >> 1;
        three_q  = period - (period >> 2);
        is_x1    = (clk_div == 2'b00);
        len      = BIT_W'(len_of(char_len));
        nbits    = len + BIT_W'(par_en);
        two_stop = (stop_sel == 2'b11);
        one_half = (stop_sel == 2'b10) && !is_x1;
        aligned  = DATA_W'({{DATA_W{1'b1}}, shreg} >> (BIT_W'(DATA_W) - len));
        par_bad  = par_en && (par_even ? acc : !acc);
    end

    // Bit-level receive sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '1;
            acc       <= 1'b0;
            fe_first  <= 1'b0;
            done      <= 1'b0;
            done_data <= '0;
            done_pe   <= 1'b0;
            done_fe   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: if (!rx_line) begin
                        shreg    <= '1;
                        acc      <= 1'b0;
                        idx      <= '0;
                        fe_first <= 1'b0;
                        if (is_x1) begin
                            state <= RX_BITS;
                            cnt   <= '0;
                        end else begin
                            state <= RX_START;
                            cnt   <= half - 1'b1;
                        end
                    end
                    RX_START: if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (rx_line) begin
                        state <= RX_IDLE;
                    end else begin
                        state <= RX_BITS;
                        cnt   <= period - 1'b1;
                    end
                    RX_BITS: if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        acc <= acc ^ rx_line;
                        if (idx < len) shreg <= {rx_line, shreg[DATA_W-1:1]};
                        cnt <= period - 1'b1;
                        if (idx == nbits - 1'b1) state <= RX_STOP1;
                        else                     idx   <= idx + 1'b1;
                    end
                    RX_STOP1: if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (two_stop || one_half) begin
                        fe_first <= !rx_line;
                        state    <= RX_STOP2;
                        cnt      <= two_stop ? period - 1'b1 : three_q - 1'b1;
                    end else begin
                        state     <= RX_IDLE;
                        done      <= 1'b1;
                        done_data <= aligned;
                        done_pe   <= par_bad;
                        done_fe   <= !rx_line;
                    end
                    RX_STOP2: if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        state     <= RX_IDLE;
                        done      <= 1'b1;
                        done_data <= aligned;
                        done_pe   <= par_bad;
                        done_fe   <= fe_first || !rx_line;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // Disabling the receiver returns the sequencer to idle
    assert_disable_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == RX_IDLE);

    // Completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/rx_hold_status.sv
// Holding register and status: captures completed characters, keeps the
// ready flag and sticky error flags, and forms the interrupt request
// from the selected mode. Assumes completion pulses are single-cycle.
module rx_hold_status
    import rx_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] done_data,
    input  logic              done_pe,
    input  logic              done_fe,
    input  logic              rd,
    input  logic              err_clr,
    input  logic              arm_first,
    input  logic [1:0]        int_mode,
    input  logic              par_sc,
    output logic [DATA_W-1:0] hold,
    output logic              ready,
    output logic              pe_st,
    output logic              fe_st,
    output logic              ov_st,
    output logic              irq
);
    logic armed, first_pend, ov_evt, sc_pend, first_mode;

    assign ov_evt     = done && ready && !rd;
    assign first_mode = (int_mode == 2'b01);

    // Data capture, ready flag and sticky errors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= '0;
            ready <= 1'b0;
            pe_st <= 1'b0;
            fe_st <= 1'b0;
            ov_st <= 1'b0;
        end else begin
            if (done) begin
                hold  <= done_data;
                ready <= 1'b1;
            end else if (rd) begin
                ready <= 1'b0;
            end
            ov_st <= (ov_st && !err_clr) || ov_evt;
            pe_st <= (pe_st && !err_clr) || (done && done_pe);
            fe_st <= (fe_st && !err_clr) || (done && done_fe);
        end
    end

    // First-character interrupt arming and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b1;
            first_pend <= 1'b0;
        end else begin
            if (arm_first)               armed <= 1'b1;
            else if (done && first_mode) armed <= 1'b0;
            if (done && first_mode && armed) first_pend <= 1'b1;
            else if (rd)                     first_pend <= 1'b0;
        end
    end

    // Interrupt request per mode
    always_comb begin
        sc_pend = fe_st || ov_st || (pe_st && par_sc);
        case (int_mode)
            2'b00:   irq = 1'b0;
            2'b01:   irq = first_pend || sc_pend;
            2'b10:   irq = ready || sc_pend;
            default: irq = sc_pend;
        endcase
    end

    assert_ready_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !done |=> !ready);
    assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done && ready && !rd |=> ov_st);
    assert_ov_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ov_st && !err_clr |=> ov_st);
    assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !done |=> !pe_st && !fe_st && !ov_st);
    assert_mode_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode == 2'b00 |-> !irq);

endmodule

// File: rtl/serial_rx_channel.sv
// Top: one asynchronous receive channel. Joins the frame engine to the
// holding/status stage and packs the status byte (bit6 framing,
// bit5 overrun, bit4 parity, bit0 ready). Assumes control fields are
// held stable while a character is in flight.
module serial_rx_channel
    import rx_cfg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       cfg_rx_en,
    input  logic [1:0] cfg_clk_div,
    input  logic [1:0] cfg_char_len,
    input  logic [1:0] cfg_stop,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_par_sc,
    input  logic [1:0] cfg_int_mode,
    input  logic       cmd_rd_data,
    input  logic       cmd_err_clr,
    input  logic       cmd_arm_first,
    output logic [7:0] rd_data,
    output logic [7:0] rx_status,
    output logic       irq_rx
);
    logic              done, done_pe, done_fe;
    logic [DATA_W-1:0] done_data;
    logic              ready, pe_st, fe_st, ov_st;

    rx_frame_engine #(.CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .en        (cfg_rx_en),
        .clk_div   (cfg_clk_div),
        .char_len  (cfg_char_len),
        .stop_sel  (cfg_stop),
        .par_en    (cfg_par_en),
        .par_even  (cfg_par_even),
        .done      (done),
        .done_data (done_data),
        .done_pe   (done_pe),
        .done_fe   (done_fe)
    );

    rx_hold_status u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .done_data (done_data),
        .done_pe   (done_pe),
        .done_fe   (done_fe),
        .rd        (cmd_rd_data),
        .err_clr   (cmd_err_clr),
        .arm_first (cmd_arm_first),
        .int_mode  (cfg_int_mode),
        .par_sc    (cfg_par_sc),
        .hold      (rd_data),
        .ready     (ready),
        .pe_st     (pe_st),
        .fe_st     (fe_st),
        .ov_st     (ov_st),
        .irq       (irq_rx)
    );

    // Status byte packing
    assign rx_status = {1'b0, fe_st, ov_st, pe_st, 3'b000, ready};

endmodule

// File: tb/serial_rx_channel_test.sv
module serial_rx_channel_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       cfg_rx_en = 1'b0;
    logic [1:0] cfg_clk_div = 2'b01;
    logic [1:0] cfg_char_len = 2'b11;
    logic [1:0] cfg_stop = 2'b01;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b1;
    logic       cfg_par_sc = 1'b0;
    logic [1:0] cfg_int_mode = 2'b00;
    logic       cmd_rd_data = 1'b0;
    logic       cmd_err_clr = 1'b0;
    logic       cmd_arm_first = 1'b0;
    logic [7:0] rd_data, rx_status;
    logic       irq_rx;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    serial_rx_channel uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_rx_en(cfg_rx_en),
        .cfg_clk_div(cfg_clk_div), .cfg_char_len(cfg_char_len), .cfg_stop(cfg_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_par_sc(cfg_par_sc),
        .cfg_int_mode(cfg_int_mode), .cmd_rd_data(cmd_rd_data), .cmd_err_clr(cmd_err_clr),
        .cmd_arm_first(cmd_arm_first), .rd_data(rd_data), .rx_status(rx_status),
        .irq_rx(irq_rx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic int clocks_of(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (16 << (code - 1));
    endfunction

    function automatic int bits_of(input logic [1:0] code);
        case (code)
            2'b00:   return 5;
            2'b01:   return 7;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction

    // Drive one frame: start, nb data bits, optional parity, first stop
    // (n clocks), optional second stop portion (s2_clks), then idle.
    task automatic send(input int n, input int nb, input logic [7:0] d,
                        input bit use_par, input bit pbit, input bit s1,
                        input int s2_clks, input bit s2);
        rx_line = 1'b0;
        repeat (n) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_line = d[i];
            repeat (n) @(negedge clk);
        end
        if (use_par) begin
            rx_line = pbit;
            repeat (n) @(negedge clk);
        end
        rx_line = s1;
        repeat (n) @(negedge clk);
        if (s2_clks > 0) begin
            rx_line = s2;
            repeat (s2_clks) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (2 * n + 4) @(negedge clk);
    endtask

    task automatic pulse_rd();
        cmd_rd_data = 1'b1; @(negedge clk); cmd_rd_data = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        cmd_err_clr = 1'b1; @(negedge clk); cmd_err_clr = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_arm();
        cmd_arm_first = 1'b1; @(negedge clk); cmd_arm_first = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        check(rx_status == 8'h00, "R1 status", rx_status, 8'h00);
        check(irq_rx == 1'b0, "R1 irq", {7'd0, irq_rx}, 8'h00);
    endtask

    task automatic t_basic();
        cfg_clk_div = 2'b01; cfg_char_len = 2'b11;
        send(16, 8, 8'hA5, 0, 0, 1, 0, 1);
        check(rd_data == 8'hA5, "R2 R3 data x16", rd_data, 8'hA5);
        check(rx_status == 8'h01, "R7 ready set", rx_status, 8'h01);
        pulse_rd();
        check(rx_status == 8'h00, "R7 read clears", rx_status, 8'h00);
    endtask

    task automatic t_lengths();
        for (int c = 0; c < 4; c++) begin
            logic [7:0] d, mask, exp;
            int nb;
            cfg_char_len = 2'(c);
            cfg_clk_div = 2'(c);
            nb = bits_of(2'(c));
            d = 8'h5A ^ 8'(c * 8'h21);
            mask = 8'((1 << nb) - 1);
            exp = (d & mask) | ~mask;
            send(clocks_of(2'(c)), nb, d, 0, 0, 1, 0, 1);
            check(rd_data == exp, "R3 length code and fill", rd_data, exp);
            check(rx_status == 8'h01, "R2 divisor timing", rx_status, 8'h01);
            pulse_rd();
        end
        cfg_char_len = 2'b11;
    endtask

    task automatic t_glitch();
        cfg_clk_div = 2'b01;
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        check(rx_status == 8'h00, "R2 short low rejected", rx_status, 8'h00);
    endtask

    task automatic t_parity();
        logic [7:0] d;
        d = 8'h37;
        cfg_clk_div = 2'b01; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        send(16, 8, d, 1, ^d, 1, 0, 1);
        check(rx_status == 8'h01, "R4 even ok", rx_status, 8'h01);
        pulse_rd();
        send(16, 8, d, 1, ~^d, 1, 0, 1);
        check(rx_status == 8'h11, "R4 even bad", rx_status, 8'h11);
        pulse_rd();
        cfg_par_even = 1'b0;
        send(16, 8, d, 1, ~^d, 1, 0, 1);
        check(rx_status == 8'h11, "R8 parity sticky after good char", rx_status, 8'h11);
        pulse_rd();
        pulse_clr();
        check(rx_status == 8'h00, "R8 error clear", rx_status, 8'h00);
        send(16, 8, d, 1, ^d, 1, 0, 1);
        check(rx_status == 8'h11, "R4 odd bad", rx_status, 8'h11);
        pulse_rd(); pulse_clr();
        cfg_par_en = 1'b0;
    endtask

    task automatic t_framing();
        cfg_clk_div = 2'b01; cfg_stop = 2'b01;
        send(16, 8, 8'h81, 0, 0, 0, 0, 1);
        check(rx_status == 8'h41, "R5 one stop low", rx_status, 8'h41);
        pulse_rd(); pulse_clr();
        cfg_stop = 2'b11;
        send(16, 8, 8'h81, 0, 0, 1, 16, 0);
        check(rx_status == 8'h41, "R5 second stop low", rx_status, 8'h41);
        pulse_rd(); pulse_clr();
        send(16, 8, 8'h81, 0, 0, 1, 16, 1);
        check(rx_status == 8'h01, "R5 two stops ok", rx_status, 8'h01);
        pulse_rd();
        cfg_stop = 2'b10;
        send(16, 8, 8'h81, 0, 0, 1, 8, 0);
        check(rx_status == 8'h41, "R5 half stop low", rx_status, 8'h41);
        pulse_rd(); pulse_clr();
        cfg_clk_div = 2'b00;
        send(1, 8, 8'h66, 0, 0, 1, 0, 1);
        check(rx_status == 8'h01 && rd_data == 8'h66, "R5 x1 1.5 acts as 1",
              rx_status, 8'h01);
        pulse_rd(); pulse_clr();
        cfg_stop = 2'b01; cfg_clk_div = 2'b01;
    endtask

    task automatic t_overrun();
        send(16, 8, 8'h11, 0, 0, 1, 0, 1);
        send(16, 8, 8'h22, 0, 0, 1, 0, 1);
        check(rx_status == 8'h21, "R6 overrun flag", rx_status, 8'h21);
        check(rd_data == 8'h22, "R6 newer char kept", rd_data, 8'h22);
        pulse_rd();
        check(rx_status == 8'h20, "R8 overrun sticky after read", rx_status, 8'h20);
        pulse_clr();
    endtask

    task automatic t_enable();
        cfg_rx_en = 1'b0;
        send(16, 8, 8'h3C, 0, 0, 1, 0, 1);
        check(rx_status == 8'h00, "R9 disabled ignores line", rx_status, 8'h00);
        cfg_rx_en = 1'b1;
    endtask

    task automatic t_irq();
        cfg_int_mode = 2'b00;
        send(16, 8, 8'h01, 0, 0, 0, 0, 1);
        check(irq_rx == 1'b0, "R10 mode off with error", {7'd0, irq_rx}, 8'h00);
        pulse_rd(); pulse_clr();
        cfg_int_mode = 2'b10;
        send(16, 8, 8'h02, 0, 0, 1, 0, 1);
        check(irq_rx == 1'b1, "R12 every char", {7'd0, irq_rx}, 8'h01);
        pulse_rd();
        check(irq_rx == 1'b0, "R12 drops on read", {7'd0, irq_rx}, 8'h00);
        cfg_int_mode = 2'b01;
        pulse_arm();
        send(16, 8, 8'h03, 0, 0, 1, 0, 1);
        check(irq_rx == 1'b1, "R11 first char", {7'd0, irq_rx}, 8'h01);
        pulse_rd();
        send(16, 8, 8'h04, 0, 0, 1, 0, 1);
        check(irq_rx == 1'b0, "R11 later char silent", {7'd0, irq_rx}, 8'h00);
        pulse_rd();
        pulse_arm();
        send(16, 8, 8'h05, 0, 0, 1, 0, 1);
        check(irq_rx == 1'b1, "R11 rearmed", {7'd0, irq_rx}, 8'h01);
        pulse_rd();
        cfg_int_mode = 2'b11;
        send(16, 8, 8'h06, 0, 0, 1, 0, 1);
        check(irq_rx == 1'b0, "R13 good char silent", {7'd0, irq_rx}, 8'h00);
        pulse_rd();
        cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_par_sc = 1'b0;
        send(16, 8, 8'h07, 1, ~^8'h07, 1, 0, 1);
        check(irq_rx == 1'b0 && rx_status == 8'h11, "R13 parity not special",
              rx_status, 8'h11);
        cfg_par_sc = 1'b1;
        @(negedge clk);
        check(irq_rx == 1'b1, "R13 parity special", {7'd0, irq_rx}, 8'h01);
        pulse_rd(); pulse_clr();
        cfg_par_en = 1'b0; cfg_par_sc = 1'b0;
        send(16, 8, 8'h08, 0, 0, 0, 0, 1);
        check(irq_rx == 1'b1, "R13 framing special", {7'd0, irq_rx}, 8'h01);
        pulse_rd(); pulse_clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg_rx_en = 1'b1;
        t_basic();
        t_lengths();
        t_glitch();
        t_parity();
        t_framing();
        t_overrun();
        t_enable();
        t_irq();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule